// File: doc/BRIEF.md
# External static memory strobe sequencer

This block runs one access to external static memory in each master-clock cycle. It drives the address bus, eight active-low chip selects, an active-low read strobe, an active-low write strobe and a data bus with a separate output-enable. It runs on an internal clock at twice the master rate. Each master cycle is therefore two internal clocks, a first half and a second half, and every strobe edge falls on a half-cycle boundary.

A requester presents a request: the direction, a chip-select number, an address and write data. The request is taken on the internal edge that ends a master cycle, when `req_ready` is high. The access then fills the next master cycle. Read data is captured as that cycle ends, and `done` pulses for one internal clock.

Each chip select has a configuration bit that chooses its read timing. With the bit clear, reads use the standard timing: the read strobe is asserted only in the second half. With the bit set, reads use the early timing: the read strobe is asserted for the whole cycle and stays low across consecutive reads to the same select. An early read that would follow a write, or a read on another select, is held back by one idle master cycle so that two devices do not drive the bus at once.

Top module: `xmem_strobe_seq`

## Requirements
- R1: While reset is applied, all chip selects and both strobes are high, `mem_dq_oe` is low, and `done` and `req_ready` are low.
- R2: In a write cycle, the selected chip select is low and the address is valid for the whole master cycle, and `mem_dq_oe` is high with `mem_dq_out` equal to the write data. The write strobe is high in the first half and low in the second half, and the read strobe stays high.
- R3: In a read on a chip select whose configuration bit is 0 (standard timing), the select is low for the whole cycle and the read strobe is high in the first half and low in the second half. The write strobe never goes low while the read strobe is low.
- R4: In a read on a chip select whose configuration bit is 1 (early timing), the read strobe is low in both halves of the cycle.
- R5: Two consecutive early reads to the same chip select are issued in adjacent master cycles, and the read strobe stays low across the boundary between them.
- R6: An early read whose preceding master cycle was a write, or a read on a different chip select, is preceded by one master cycle in which all selects and strobes are high. During that cycle the request is not accepted.
- R7: A standard-timing read is never delayed. It runs in the master cycle right after the previous access, including after a write or after a read on another select.
- R8: At the end of each access, `done` is high for exactly one internal clock, starting on the edge that ends the cycle. After a read, `rd_data` holds the value on `mem_dq_in` at that edge. After a write, `rd_data` keeps its previous value.
- R9: When no request is taken at the end of a cycle, the next master cycle has all chip selects and strobes high and `mem_dq_oe` low. Outside accesses, at most one chip select is ever low.
- R10: Bit i of `cfg_early` selects the read timing for chip select i only.
- R11: `req_ready` can be high only during the second half of a master cycle. A request is taken on the clock edge at which `req_valid` and `req_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the master rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_early | input | NUM_CS | Per-select read timing, 1 = early |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | CS_W | Chip-select number of the request |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request taken on this edge when valid |
| rd_data | output | DATA_W | Data from the last read |
| done | output | 1 | One-clock pulse when an access completes |
| mem_addr | output | ADDR_W | External address bus |
| mem_cs_n | output | NUM_CS | Active-low chip selects |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_dq_out | output | DATA_W | Data bus value driven when enabled |
| mem_dq_oe | output | 1 | Data bus output enable |
| mem_dq_in | input | DATA_W | Data bus value from memory |

## Verification
Take the falling clock edge at which a request is seen accepted as tick a. The first half of its access is then visible at tick a+1 and the second half at tick a+2. The `done` pulse, with fresh `rd_data`, appears at tick a+3. A contention wait moves the next acceptance from two ticks after the previous one to four ticks after it.

The bench logs every output at each falling edge together with the tick of each acceptance. It then checks the access strobes at exactly those offsets and checks the spacing between acceptances against the wait rule. A scoreboard queue pairs each `done` with the read value that the memory model predicts for it.

// File: rtl/xms_pkg.sv
`timescale 1ns/1ps
package xms_pkg;

   // What a master cycle is used for
   typedef enum logic [1:0] {
      SLOT_IDLE  = 2'd0,
      SLOT_READ  = 2'd1,
      SLOT_WRITE = 2'd2,
      SLOT_GAP   = 2'd3
   } slot_kind_e;

   function automatic logic slot_on_bus(slot_kind_e k);
      return (k == SLOT_READ) || (k == SLOT_WRITE);
   endfunction

endpackage

// File: rtl/xms_phase.sv
`timescale 1ns/1ps
// Half-cycle phase of the master clock, derived from the 2x internal clock
module xms_phase (
   input  logic clk,
   input  logic rst_n,
   output logic late_half
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) late_half <= 1'b0;
      else        late_half <= ~late_half;
   end

endmodule

// File: rtl/xms_sched.sv
`timescale 1ns/1ps
// Chooses the use of each master cycle and holds the current slot
module xms_sched #(
   parameter int ADDR_W = 23,
   parameter int DATA_W = 16,
   parameter int NUM_CS = 8,
   parameter int CS_W   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                late_half,
   input  logic [NUM_CS-1:0]   cfg_early,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [CS_W-1:0]     req_cs,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   output logic                req_ready,
   output xms_pkg::slot_kind_e cur_kind,
   output xms_pkg::slot_kind_e nxt_kind,
   output logic [CS_W-1:0]     nxt_cs,
   output logic [ADDR_W-1:0]   nxt_addr,
   output logic [DATA_W-1:0]   nxt_wdata,
   output logic                nxt_early
);
   import xms_pkg::*;

   logic [CS_W-1:0]   cur_cs;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] cur_wdata;
   logic              cur_early;
   logic              req_early;
   logic              bus_turn;
   logic              need_gap;

   assign req_early = cfg_early[req_cs];

   // Another driver may still hold the bus when the strobe would go low early
   assign bus_turn = (cur_kind == SLOT_WRITE) ||
                     ((cur_kind == SLOT_READ) && (cur_cs != req_cs));
   assign need_gap  = req_valid && !req_write && req_early && bus_turn;
   assign req_ready = late_half && !need_gap;

   always_comb begin
      nxt_kind  = cur_kind;
      nxt_cs    = cur_cs;
      nxt_addr  = cur_addr;
      nxt_wdata = cur_wdata;
      nxt_early = cur_early;
      if (late_half) begin
         if (!req_valid) begin
            nxt_kind = SLOT_IDLE;
         end else if (need_gap) begin
            nxt_kind = SLOT_GAP;
         end else begin
            nxt_kind  = req_write ? SLOT_WRITE : SLOT_READ;
            nxt_cs    = req_cs;
            nxt_addr  = req_addr;
            nxt_wdata = req_wdata;
            nxt_early = req_early && !req_write;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_kind  <= SLOT_IDLE;
         cur_cs    <= '0;
         cur_addr  <= '0;
         cur_wdata <= '0;
         cur_early <= 1'b0;
      end else begin
         cur_kind  <= nxt_kind;
         cur_cs    <= nxt_cs;
         cur_addr  <= nxt_addr;
         cur_wdata <= nxt_wdata;
         cur_early <= nxt_early;
      end
   end

endmodule

// File: rtl/xms_strobe_gen.sv
`timescale 1ns/1ps
// Registered pin drivers: each output is flopped for the half-cycle it covers
module xms_strobe_gen #(
   parameter int ADDR_W = 23,
   parameter int DATA_W = 16,
   parameter int NUM_CS = 8,
   parameter int CS_W   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                late_half,
   input  xms_pkg::slot_kind_e nxt_kind,
   input  logic [CS_W-1:0]     nxt_cs,
   input  logic [ADDR_W-1:0]   nxt_addr,
   input  logic [DATA_W-1:0]   nxt_wdata,
   input  logic                nxt_early,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [NUM_CS-1:0]   mem_cs_n,
   output logic                mem_rd_n,
   output logic                mem_wr_n,
   output logic [DATA_W-1:0]   mem_dq_out,
   output logic                mem_dq_oe
);
   import xms_pkg::*;

   logic              nxt_late;
   logic              on_bus;
   logic [NUM_CS-1:0] sel_nxt;

   assign nxt_late = ~late_half;
   assign on_bus   = slot_on_bus(nxt_kind);

   for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
      assign sel_nxt[g] = on_bus && (nxt_cs == CS_W'(g));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr   <= '0;
         mem_cs_n   <= '1;
         mem_rd_n   <= 1'b1;
         mem_wr_n   <= 1'b1;
         mem_dq_out <= '0;
         mem_dq_oe  <= 1'b0;
      end else begin
         mem_addr   <= nxt_addr;
         mem_cs_n   <= ~sel_nxt;
         mem_rd_n   <= !((nxt_kind == SLOT_READ) && (nxt_late || nxt_early));
         mem_wr_n   <= !((nxt_kind == SLOT_WRITE) && nxt_late);
         mem_dq_out <= nxt_wdata;
         mem_dq_oe  <= (nxt_kind == SLOT_WRITE);
      end
   end

endmodule

// File: rtl/xms_capture.sv
`timescale 1ns/1ps
// Samples read data and flags completion on the edge that ends a cycle
module xms_capture #(
   parameter int DATA_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                late_half,
   input  xms_pkg::slot_kind_e cur_kind,
   input  logic [DATA_W-1:0]   mem_dq_in,
   output logic [DATA_W-1:0]   rd_data,
   output logic                done
);
   import xms_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         done    <= 1'b0;
      end else begin
         done <= late_half && slot_on_bus(cur_kind);
         if (late_half && (cur_kind == SLOT_READ)) rd_data <= mem_dq_in;
      end
   end

endmodule

// File: rtl/xmem_strobe_seq.sv
`timescale 1ns/1ps
module xmem_strobe_seq #(
   parameter  int ADDR_W = 23,
   parameter  int DATA_W = 16,
   parameter  int NUM_CS = 8,
   localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CS-1:0] cfg_early,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [CS_W-1:0]   req_cs,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic [DATA_W-1:0] rd_data,
   output logic              done,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [NUM_CS-1:0] mem_cs_n,
   output logic              mem_rd_n,
   output logic              mem_wr_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);
   import xms_pkg::*;

   if (NUM_CS < 2 || (1 << CS_W) != NUM_CS) begin : g_bad_cs
      $error("NUM_CS must be a power of two and at least 2");
   end
   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W out of range");
   end
   if (DATA_W < 8 || DATA_W > 64) begin : g_bad_data
      $error("DATA_W out of range");
   end

   logic              late_half;
   slot_kind_e        cur_kind;
   slot_kind_e        nxt_kind;
   logic [CS_W-1:0]   nxt_cs;
   logic [ADDR_W-1:0] nxt_addr;
   logic [DATA_W-1:0] nxt_wdata;
   logic              nxt_early;

   xms_phase u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .late_half (late_half)
   );

   xms_sched #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CS(NUM_CS), .CS_W(CS_W)) u_sched (
      .clk       (clk),
      .rst_n     (rst_n),
      .late_half (late_half),
      .cfg_early (cfg_early),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_cs    (req_cs),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_ready (req_ready),
      .cur_kind  (cur_kind),
      .nxt_kind  (nxt_kind),
      .nxt_cs    (nxt_cs),
      .nxt_addr  (nxt_addr),
      .nxt_wdata (nxt_wdata),
      .nxt_early (nxt_early)
   );

   xms_strobe_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CS(NUM_CS), .CS_W(CS_W)) u_pins (
      .clk        (clk),
      .rst_n      (rst_n),
      .late_half  (late_half),
      .nxt_kind   (nxt_kind),
      .nxt_cs     (nxt_cs),
      .nxt_addr   (nxt_addr),
      .nxt_wdata  (nxt_wdata),
      .nxt_early  (nxt_early),
      .mem_addr   (mem_addr),
      .mem_cs_n   (mem_cs_n),
      .mem_rd_n   (mem_rd_n),
      .mem_wr_n   (mem_wr_n),
      .mem_dq_out (mem_dq_out),
      .mem_dq_oe  (mem_dq_oe)
   );

   xms_capture #(.DATA_W(DATA_W)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .late_half (late_half),
      .cur_kind  (cur_kind),
      .mem_dq_in (mem_dq_in),
      .rd_data   (rd_data),
      .done      (done)
   );

endmodule

// File: rtl/xmem_strobe_seq_chk.sv
`timescale 1ns/1ps
module xmem_strobe_seq_chk #(
   parameter int NUM_CS = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CS-1:0] mem_cs_n,
   input logic              mem_rd_n,
   input logic              mem_wr_n,
   input logic              mem_dq_oe,
   input logic              done,
   input logic              req_ready
);

   // R2
   wr_drives_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_wr_n |-> mem_dq_oe);

   // R2
   wr_after_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_wr_n) |-> ($stable(mem_cs_n) && (mem_cs_n != '1)));

   // R3
   rd_wr_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_rd_n && !mem_wr_n));

   // R9
   single_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~mem_cs_n));

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&mem_cs_n) |-> (mem_rd_n && mem_wr_n && !mem_dq_oe));

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   done_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(mem_cs_n) != '1));

   // R11
   ready_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> !req_ready);

endmodule

bind xmem_strobe_seq xmem_strobe_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_cs_n  (mem_cs_n),
   .mem_rd_n  (mem_rd_n),
   .mem_wr_n  (mem_wr_n),
   .mem_dq_oe (mem_dq_oe),
   .done      (done),
   .req_ready (req_ready)
);

// File: tb/xmem_strobe_seq_test.sv
`timescale 1ns/1ps
module xmem_strobe_seq_test;

   typedef struct {
      bit          wr;
      int          cs;
      logic [22:0] addr;
      logic [15:0] data;
      bit          chain;
   } req_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cfg_early = 8'b0000_0110;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [2:0]  req_cs = '0;
   logic [22:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        req_ready;
   logic [15:0] rd_data;
   logic        done;
   logic [22:0] mem_addr;
   logic [7:0]  mem_cs_n;
   logic        mem_rd_n;
   logic        mem_wr_n;
   logic [15:0] mem_dq_out;
   logic        mem_dq_oe;
   logic [15:0] mem_dq_in;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   function automatic logic [15:0] mem_word(logic [22:0] a);
      return a[15:0] ^ {9'h0, a[22:16]} ^ 16'h5A3C;
   endfunction

   assign mem_dq_in = mem_rd_n ? 16'h0000 : mem_word(mem_addr);

   xmem_strobe_seq uut (.*);

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // Trace of outputs per falling edge
   localparam int TMAX = 1024;
   logic [7:0]  t_cs [TMAX];
   logic [22:0] t_addr [TMAX];
   logic [15:0] t_dq [TMAX];
   logic        t_rd [TMAX];
   logic        t_wr [TMAX];
   logic        t_oe [TMAX];
   logic        t_done [TMAX];
   logic        t_rdy [TMAX];
   int          tick = 0;

   req_t        pend[$];
   req_t        acc_req[$];
   int          acc_tick[$];
   logic [15:0] exp_q[$];
   logic [15:0] last_rd = 16'h0000;
   int          done_seen = 0;

   // Monitor, scoreboard and driver, all at the falling edge
   always @(negedge clk) begin
      if (rst_n && tick < TMAX) begin
         t_cs[tick]   = mem_cs_n;
         t_addr[tick] = mem_addr;
         t_dq[tick]   = mem_dq_out;
         t_rd[tick]   = mem_rd_n;
         t_wr[tick]   = mem_wr_n;
         t_oe[tick]   = mem_dq_oe;
         t_done[tick] = done;
         if (done) begin
            done_seen++;
            if (exp_q.size() == 0) chk(0, "R8 unexpected done", 32'(rd_data), 0);
            else begin
               logic [15:0] e;
               e = exp_q.pop_front();
               chk(rd_data == e, "R8 read data", 32'(rd_data), 32'(e));
            end
         end
         if (pend.size() > 0) begin
            req_valid = 1'b1;
            req_write = pend[0].wr;
            req_cs    = 3'(pend[0].cs);
            req_addr  = pend[0].addr;
            req_wdata = pend[0].data;
         end else begin
            req_valid = 1'b0;
         end
         #1;
         t_rdy[tick] = req_ready;
         if (req_valid && req_ready) begin
            req_t r;
            r = pend.pop_front();
            acc_req.push_back(r);
            acc_tick.push_back(tick);
            if (!r.wr) last_rd = mem_word(r.addr);
            exp_q.push_back(last_rd);
         end
         tick++;
      end
   end

   function automatic req_t mk(bit wr, int cs, logic [22:0] a, logic [15:0] d, bit chain);
      req_t r;
      r.wr = wr; r.cs = cs; r.addr = a; r.data = d; r.chain = chain;
      return r;
   endfunction

   task automatic check_access(int i);
      req_t        r;
      req_t        p;
      int          a;
      bit          e;
      logic [7:0]  sel;
      string       rtag;
      r    = acc_req[i];
      a    = acc_tick[i];
      e    = !r.wr && cfg_early[r.cs];
      sel  = ~(8'b1 << r.cs);
      rtag = r.wr ? "R2" : (e ? "R4" : "R3");
      chk(t_cs[a+1] == sel && t_cs[a+2] == sel, "R10 select", 32'(t_cs[a+1]), 32'(sel));
      chk(t_addr[a+1] == r.addr, "R2 address", 32'(t_addr[a+1]), 32'(r.addr));
      chk(t_rd[a+1] == !e, rtag, 32'(t_rd[a+1]), 32'(!e));
      chk(t_rd[a+2] == r.wr, rtag, 32'(t_rd[a+2]), 32'(r.wr));
      chk(t_wr[a+1] == 1'b1 && t_wr[a+2] == !r.wr, rtag, 32'({t_wr[a+1], t_wr[a+2]}), 32'({1'b1, !r.wr}));
      chk(t_oe[a+1] == r.wr && t_oe[a+2] == r.wr, "R2 output enable", 32'(t_oe[a+1]), 32'(r.wr));
      if (r.wr) chk(t_dq[a+1] == r.data, "R2 write data", 32'(t_dq[a+1]), 32'(r.data));
      chk(t_done[a+3] == 1'b1 && t_done[a+2] == 1'b0, "R8 done timing", 32'({t_done[a+2], t_done[a+3]}), 32'b01);
      if (i > 0 && r.chain) begin
         int gap;
         p   = acc_req[i-1];
         gap = (e && (p.wr || p.cs != r.cs)) ? 4 : 2;
         chk(a - acc_tick[i-1] == gap, e ? "R6 spacing" : "R7 spacing", 32'(a - acc_tick[i-1]), 32'(gap));
         if (gap == 4)
            chk(t_cs[a-1] == 8'hFF && t_cs[a] == 8'hFF && t_rd[a-1] && t_rd[a] && t_wr[a-1] && t_wr[a],
                "R6 idle wait", 32'({t_cs[a-1], t_cs[a]}), 32'hFFFF);
         if (e && !p.wr && cfg_early[p.cs] && p.cs == r.cs)
            chk(t_rd[a] == 1'b0 && t_rd[a+1] == 1'b0, "R5 continuous strobe", 32'({t_rd[a], t_rd[a+1]}), 32'b00);
      end
   endtask

   task automatic drain();
      while (pend.size() != 0) @(negedge clk);
      repeat (12) @(negedge clk);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #80000;
      n_chk++;
      n_fail++;
      $display("FAIL R11 watchdog: actual %0d ticks expected completion", tick);
      summary();
   end

   initial begin
      int last;
      int n1;
      repeat (3) @(negedge clk);
      // R1
      chk(mem_cs_n == 8'hFF && mem_rd_n && mem_wr_n && !mem_dq_oe, "R1 reset strobes",
          32'({mem_cs_n, mem_rd_n, mem_wr_n, mem_dq_oe}), 32'({8'hFF, 3'b110}));
      chk(!done && !req_ready, "R1 reset flags", 32'({done, req_ready}), 0);
      @(negedge clk);
      #1 rst_n = 1'b1;

      pend.push_back(mk(1, 0, 23'h000100, 16'h1234, 0));
      pend.push_back(mk(0, 0, 23'h000200, 16'h0, 1));
      pend.push_back(mk(0, 1, 23'h400001, 16'h0, 1));
      pend.push_back(mk(0, 1, 23'h400002, 16'h0, 1));
      pend.push_back(mk(0, 2, 23'h7FFFFF, 16'h0, 1));
      pend.push_back(mk(1, 2, 23'h000040, 16'hBEEF, 1));
      pend.push_back(mk(0, 2, 23'h000041, 16'h0, 1));
      pend.push_back(mk(0, 3, 23'h123456, 16'h0, 1));
      drain();
      n1   = acc_req.size();
      last = acc_tick[n1-1];
      // R9: nothing pending, so the next master cycle is quiet
      chk(t_cs[last+3] == 8'hFF && t_cs[last+4] == 8'hFF && t_rd[last+3] && t_rd[last+4] &&
          t_wr[last+3] && t_wr[last+4] && !t_oe[last+3], "R9 idle",
          32'({t_cs[last+3], t_cs[last+4]}), 32'hFFFF);

      pend.push_back(mk(0, 1, 23'h2AAAAA, 16'h0, 0));
      pend.push_back(mk(0, 7, 23'h000007, 16'h0, 1));
      pend.push_back(mk(1, 7, 23'h000055, 16'h0F0F, 1));
      pend.push_back(mk(0, 7, 23'h000056, 16'h0, 1));
      drain();

      for (int i = 0; i < acc_req.size(); i++) check_access(i);
      chk(exp_q.size() == 0 && done_seen == acc_req.size(), "R8 done count",
          32'(done_seen), 32'(acc_req.size()));
      begin
         int bad;
         bad = 0;
         for (int t = 0; t + 1 < tick && t + 1 < TMAX; t++) if (t_rdy[t] && t_rdy[t+1]) bad++;
         chk(bad == 0, "R11 ready half", 32'(bad), 0);
      end
      summary();
   end

endmodule